// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block tracks replacement state for an N-way set-associative cache. Every way of every set has one staleness flag. A flag of 1 marks a line that has gone unreferenced for a while, and a flag of 0 marks a line that was recently referenced. Hits and fills clear the flag of the way they touch. A miss query names a set. The block answers in the same cycle with the way to evict. It picks the lowest-numbered way whose flag is 1.

A miss query can find that no way in the set is stale. In that case the block sets every flag of that set back to 1 at the next clock edge. In the same cycle it reports way 0, because way 0 is the first candidate once all flags are set. Hit, fill and miss use separate ports, so one cycle can update one set and query another. Each set holds its own state. The update each set applies at a clock edge is one of four named row actions:

- HOLD: nothing touches the set.
- TOUCH: a hit or fill clears a flag.
- REARM: a miss found no candidate.
- REARM_TOUCH: a re-arm and a hit or fill land on the same set. The touched way ends at 0 and every other way ends at 1.

At reset every set moves to the all-stale state.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset all flags are 1, so the first miss query to any set reports way 0.
- R2: For a miss query, victim_way is the lowest-numbered way (way 0 is leftmost) of miss_set whose flag is 1.
- R3: A hit clears the flag of hit_way in hit_set from the next cycle on.
- R4: A fill clears the flag of fill_way in fill_set from the next cycle on.
- R5: A miss query to a set with no flag at 1 reports way 0 in the same cycle and sets all flags of that set to 1 at the clock edge.
- R6: victim_valid is 1 exactly in the cycles where miss_en is 1, with no added latency.
- R7: A miss query to a set that has a candidate leaves the flags unchanged, so a repeated query with no touch in between reports the same way.
- R8: Hits, fills and re-arms change only the flags of the set they address.
- R9: When a re-arm and a hit or fill hit the same set in one cycle, the touched way ends with flag 0 and every other way ends with flag 1.
- R10: A hit and a fill to the same set in the same cycle is illegal and is reported by an assertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_en | input | 1 | Miss query strobe |
| miss_set | input | $clog2(SETS) | Set addressed by the miss query |
| hit_en | input | 1 | Hit strobe |
| hit_set | input | $clog2(SETS) | Set of the hit |
| hit_way | input | $clog2(WAYS) | Way that hit |
| fill_en | input | 1 | Fill (insertion) strobe |
| fill_set | input | $clog2(SETS) | Set being filled |
| fill_way | input | $clog2(WAYS) | Way being filled |
| victim_way | output | $clog2(WAYS) | Way chosen for eviction in miss_set |
| victim_valid | output | 1 | victim_way is meaningful this cycle |

## Verification
The bench builds the block with four ways and eight sets. With four ways, a set can be driven quickly through all partial flag patterns, including a full set with no candidate, so the priority order and the re-arm path are exercised many times. Eight sets keep cross-set isolation checks and the random mix dense enough that queries often land on sets that were just touched, re-armed, or both in the same cycle.

// File: rtl/nru_pkg.sv
package nru_pkg;

    // Update applied to one set's flag row at a clock edge
    typedef enum logic [1:0] {
        ROW_HOLD        = 2'b00,
        ROW_TOUCH       = 2'b01,
        ROW_REARM       = 2'b10,
        ROW_REARM_TOUCH = 2'b11
    } row_act_e;

endpackage

// File: rtl/nru_way_dec.sv
module nru_way_dec #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             en,
    input  logic [WAY_W-1:0] way,
    output logic [WAYS-1:0]  mask
);
    for (genvar w = 0; w < WAYS; w++) begin : g_bit
        assign mask[w] = en && (way == WAY_W'(w));
    end
endmodule

// File: rtl/nru_first_one.sv
module nru_first_one #(
    parameter int W  = 4,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest index set wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/nru_set_row.sv
module nru_set_row
    import nru_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rearm,
    input  logic [WAYS-1:0] clr_mask,
    output logic [WAYS-1:0] stale
);
    row_act_e        act;
    logic [WAYS-1:0] stale_q;
    logic [WAYS-1:0] stale_d;

    always_comb begin
        act = row_act_e'({rearm, |clr_mask});
    end

    always_comb begin
        stale_d = stale_q;
        unique case (act)
            ROW_HOLD:        stale_d = stale_q;
            ROW_TOUCH:       stale_d = stale_q & ~clr_mask;
            ROW_REARM:       stale_d = '1;
            ROW_REARM_TOUCH: stale_d = ~clr_mask;
            default:         stale_d = stale_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stale_q <= '1;
        else        stale_q <= stale_d;
    end

    assign stale = stale_q;
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_en,
    input  logic [SET_W-1:0] miss_set,
    input  logic             hit_en,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_valid
);
    logic [WAYS-1:0] hit_mask;
    logic [WAYS-1:0] fill_mask;
    logic [WAYS-1:0] stale_all [SETS];
    logic [WAYS-1:0] sel_row;
    logic            cand_found;
    logic [WAY_W-1:0] cand_idx;

    nru_way_dec #(.WAYS(WAYS), .WAY_W(WAY_W)) u_hit_dec (
        .en   (hit_en),
        .way  (hit_way),
        .mask (hit_mask)
    );

    nru_way_dec #(.WAYS(WAYS), .WAY_W(WAY_W)) u_fill_dec (
        .en   (fill_en),
        .way  (fill_way),
        .mask (fill_mask)
    );

    // Row read for the queried set
    always_comb begin
        sel_row = '0;
        for (int s = 0; s < SETS; s++) begin
            if (miss_set == SET_W'(s)) sel_row = stale_all[s];
        end
    end

    nru_first_one #(.W(WAYS), .IW(WAY_W)) u_pick (
        .vec   (sel_row),
        .found (cand_found),
        .idx   (cand_idx)
    );

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic            hit_here;
        logic            fill_here;
        logic            rearm_here;
        logic [WAYS-1:0] clr_here;

        assign hit_here   = hit_en  && (hit_set  == SET_W'(s));
        assign fill_here  = fill_en && (fill_set == SET_W'(s));
        assign rearm_here = miss_en && (miss_set == SET_W'(s)) && !cand_found;
        assign clr_here   = (hit_here  ? hit_mask  : '0)
                          | (fill_here ? fill_mask : '0);

        nru_set_row #(.WAYS(WAYS)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .rearm    (rearm_here),
            .clr_mask (clr_here),
            .stale    (stale_all[s])
        );
    end

    // No candidate: after re-arm way 0 is the leftmost stale way
    assign victim_way   = cand_found ? cand_idx : '0;
    assign victim_valid = miss_en;
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_en,
    input logic [SET_W-1:0] miss_set,
    input logic             hit_en,
    input logic [SET_W-1:0] hit_set,
    input logic [WAY_W-1:0] hit_way,
    input logic             fill_en,
    input logic [SET_W-1:0] fill_set,
    input logic [WAY_W-1:0] fill_way,
    input logic [WAY_W-1:0] victim_way,
    input logic             victim_valid
);
    logic touch_miss_set;
    assign touch_miss_set = (hit_en  && hit_set  == miss_set)
                         || (fill_en && fill_set == miss_set);

    p_no_hit_fill_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_en && fill_en && hit_set == fill_set));

    p_repeat_query_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(miss_en) && !$past(touch_miss_set) && miss_en
         && miss_set == $past(miss_set))
        |-> (victim_way == $past(victim_way)));

    p_hit_not_next_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit_en) && $past(hit_way) != '0 && miss_en
         && miss_set == $past(hit_set))
        |-> (victim_way != $past(hit_way)));

    p_fill_not_next_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_en) && $past(fill_way) != '0 && miss_en
         && miss_set == $past(fill_set))
        |-> (victim_way != $past(fill_way)));

    p_valid_with_query_r6: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> miss_en);
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_en      (miss_en),
    .miss_set     (miss_set),
    .hit_en       (hit_en),
    .hit_set      (hit_set),
    .hit_way      (hit_way),
    .fill_en      (fill_en),
    .fill_set     (fill_set),
    .fill_way     (fill_way),
    .victim_way   (victim_way),
    .victim_valid (victim_valid)
);

// File: tb/nru_victim_sel_tb_top.sv
`timescale 1ns/1ps
module nru_victim_sel_tb_top;
    localparam int WAYS = 4;
    localparam int SETS = 8;
    localparam int WW   = $clog2(WAYS);
    localparam int SW   = $clog2(SETS);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          miss_en, hit_en, fill_en;
    logic [SW-1:0] miss_set, hit_set, fill_set;
    logic [WW-1:0] hit_way, fill_way;
    logic [WW-1:0] victim_way;
    logic          victim_valid;

    int total = 0;
    int bad   = 0;
    bit model [SETS][WAYS];

    always #10 clk = ~clk;

    nru_victim_sel #(.WAYS(WAYS), .SETS(SETS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_en(miss_en), .miss_set(miss_set),
        .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .victim_way(victim_way), .victim_valid(victim_valid)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive, compare to model before the edge, update model at the edge
    task automatic cyc(bit m, int ms, bit h, int hs, int hw,
                       bit f, int fs, int fw, string req);
        int  exp_way;
        bit  found;
        @(negedge clk);
        miss_en  = m;  miss_set = ms[SW-1:0];
        hit_en   = h;  hit_set  = hs[SW-1:0]; hit_way  = hw[WW-1:0];
        fill_en  = f;  fill_set = fs[SW-1:0]; fill_way = fw[WW-1:0];
        #2;
        check("R6", "victim_valid", int'(victim_valid), int'(m));
        exp_way = 0;
        found   = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && model[ms][w]) begin
                exp_way = w;
                found   = 1'b1;
            end
        end
        if (m) check(req, "victim_way", int'(victim_way), exp_way);
        @(posedge clk);
        if (m && !found) for (int w = 0; w < WAYS; w++) model[ms][w] = 1'b1;
        if (h) model[hs][hw] = 1'b0;
        if (f) model[fs][fw] = 1'b0;
    endtask

    task automatic miss(int s, string req);
        cyc(1, s, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic fill(int s, int w);
        cyc(0, 0, 0, 0, 0, 1, s, w, "R4");
    endtask

    task automatic hit(int s, int w);
        cyc(0, 0, 1, s, w, 0, 0, 0, "R3");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        miss_en = 0; hit_en = 0; fill_en = 0;
        miss_set = '0; hit_set = '0; fill_set = '0;
        hit_way = '0; fill_way = '0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) model[s][w] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every set starts all-stale, first victim way 0
        for (int s = 0; s < SETS; s++) miss(s, "R1");

        // R2 / R4: leftmost stale way moves right as ways fill
        fill(1, 0); miss(1, "R2");
        fill(1, 1); miss(1, "R2");
        fill(1, 3); miss(1, "R2");
        // R3: hit on the current candidate moves the victim
        hit(2, 0); hit(2, 1); miss(2, "R3");
        // R7: repeated queries keep the answer
        miss(2, "R7"); miss(2, "R7");

        // R5: full set re-arms and reports way 0, then way 0 again
        fill(3, 0); fill(3, 1); fill(3, 2); fill(3, 3);
        miss(3, "R5");
        miss(3, "R7");
        fill(3, 0); miss(3, "R5");

        // R9: re-arm with a same-cycle hit on way 2
        fill(4, 0); fill(4, 1); fill(4, 2); fill(4, 3);
        cyc(1, 4, 1, 4, 2, 0, 0, 0, "R9");
        fill(4, 0); fill(4, 1); miss(4, "R9");
        // R9: re-arm with a same-cycle fill on way 0
        fill(6, 0); fill(6, 1); fill(6, 2); fill(6, 3);
        cyc(1, 6, 0, 0, 0, 1, 6, 0, "R9");
        miss(6, "R9");

        // R8: heavy activity in set 5 leaves set 7 untouched
        fill(5, 0); fill(5, 1); fill(5, 2); fill(5, 3);
        miss(5, "R5");
        miss(7, "R8");
        cyc(1, 0, 1, 5, 0, 1, 7, 0, "R8");
        miss(7, "R8");
        miss(5, "R8");

        // Mixed traffic; hit and fill never share a set (R10 is illegal)
        for (int i = 0; i < 4000; i++) begin
            bit m, h, f;
            int ms, hs, hw, fs, fw;
            m  = ($urandom_range(0, 3) != 0);
            h  = ($urandom_range(0, 2) == 0);
            f  = ($urandom_range(0, 2) == 0);
            ms = $urandom_range(0, SETS - 1);
            hs = $urandom_range(0, SETS - 1);
            fs = $urandom_range(0, SETS - 1);
            hw = $urandom_range(0, WAYS - 1);
            fw = $urandom_range(0, WAYS - 1);
            if (h && f && hs == fs) f = 1'b0;
            cyc(m, ms, h, hs, hw, f, fs, fw, "R2");
        end

        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R6");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule